// File: doc/BRIEF.md
# Byte-Lane Data RAM Access Unit

This block sits beside the arithmetic core of a small signal processor and moves single bytes between a 3072-byte on-chip data RAM and a 24-bit RAM data register. Each RAM instruction carries a lane number that picks one of the three bytes of the data register. A load copies one RAM byte into that lane and leaves the other two lanes as they were. A store copies that lane out to RAM.

The core supplies the operand for each instruction. An instruction flag chooses whether a base register is added to the operand. The sum is formed at full 24-bit width. Any access whose address lands at 3072 or above is dropped without effect, and the address never wraps into the array. A lane code of 3 is rejected, and a one-cycle illegal-instruction pulse reports it. The base register is loaded through its own write port. The core can also load the data register directly. When a load's merge and a direct load reach the data register on the same edge, the merge takes priority.

Top module: `lane_ram_unit`

## Requirements
- R1: Reset clears the data register and the base register and holds the illegal pulse low. The contents of the RAM are undefined after reset.
- R2: A store instruction writes the selected lane of the data register to the RAM byte at the effective address. The instruction has `opcode[15:11]` = 5'b11101, with `opcode[9:8]` as the lane and `opcode[10]` as the base flag.
- R3: A load instruction replaces only the selected lane of the data register with the RAM byte at the effective address and keeps the other two lanes. The load has `opcode[15:11]` = 5'b01101. The data register shows the new value after the second rising edge following the cycle in which the instruction is presented.
- R4: The lane code in `opcode[9:8]` selects the data register bits: 0 selects bits 7:0, 1 selects bits 15:8, and 2 selects bits 23:16.
- R5: When `opcode[10]` is 1, the effective address is the operand plus the base register. When it is 0, the effective address is the operand alone. The base register changes only when `baseWrEn` is high, and it takes `baseWrData` on that edge.
- R6: A load whose effective address is 0xC00 or higher leaves the data register unchanged.
- R7: A store whose effective address is 0xC00 or higher changes no RAM byte. This includes addresses whose low 12 bits fall inside the array.
- R8: A load or store with lane code 3 makes `illegalOp` high for exactly the one cycle after it is presented. It performs no access.
- R9: The operand-plus-base sum is 24 bits wide and wraps modulo 2^24. The range check applies to the wrapped sum, so 0xFFFFFF plus 6 addresses byte 5.
- R10: When `opValid` is low, or when `opcode[15:11]` matches neither the load nor the store pattern, the instruction causes no RAM or data-register change.
- R11: When `dataWrEn` is high, the data register takes `dataWrData` on the next edge, unless a load merge lands on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An instruction is presented this cycle |
| opcode | input | 16 | Instruction word |
| operand | input | 24 | Address operand from the core |
| baseWrEn | input | 1 | Load the base register |
| baseWrData | input | 24 | New base register value |
| dataWrEn | input | 1 | Load the data register directly |
| dataWrData | input | 24 | New data register value |
| dataReg | output | 24 | Current RAM data register |
| illegalOp | output | 1 | One-cycle pulse for lane code 3 |

## Verification
The bench fills every one of the 3072 bytes through stores. The lane rotates with the address and the byte value is an arithmetic hash of the address, so a wrong lane pick or a wrong address shows up as a different byte. It then loads every address back, alternating between the direct form and the based form. Each load starts from a data register preset that differs per address, which separates a lane merge from a whole-register overwrite.

Boundary patterns target the range check and the address sum:
- addresses 0xBFF and 0xC00 reached both directly and through the base register;
- a store to 0x1000, which would alias byte 0 if the address were truncated;
- a base of 0xFFFFFF, which wraps to a low address;
- lane code 3, non-RAM opcodes and idle cycles, each of which must change nothing observable.

// File: rtl/lane_ram_pkg.sv
package lane_ram_pkg;

  // Strobes from decode to datapath
  typedef struct packed {
    logic       rdEn;
    logic       wrEn;
    logic       useBase;
    logic [1:0] lane;
  } ramStrobes_t;

  // opcode[15:11] of the load and store forms
  localparam logic [4:0] RD_MAJOR = 5'b01101;
  localparam logic [4:0] WR_MAJOR = 5'b11101;
  localparam logic [1:0] BAD_LANE = 2'b11;

endpackage

// File: rtl/lane_ram_ctrl.sv
module lane_ram_ctrl
  import lane_ram_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [15:0] opcode,
  output ramStrobes_t strobes,
  output logic        illegalOp
);

  logic isRd;
  logic isWr;
  logic laneOk;

  assign isRd   = (opcode[15:11] == RD_MAJOR);
  assign isWr   = (opcode[15:11] == WR_MAJOR);
  assign laneOk = (opcode[9:8] != BAD_LANE);

  always_comb begin
    strobes.rdEn    = opValid && isRd && laneOk;
    strobes.wrEn    = opValid && isWr && laneOk;
    strobes.useBase = opcode[10];
    strobes.lane    = opcode[9:8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) illegalOp <= 1'b0;
    else       illegalOp <= opValid && (isRd || isWr) && !laneOk;
  end

  // R8
  illegal_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> ($past(opValid) && $past(opcode[9:8]) == BAD_LANE));

endmodule

// File: rtl/lane_ram_dpath.sv
module lane_ram_dpath
  import lane_ram_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int BYTE_W    = 8,
  parameter int RAM_BYTES = 3072
) (
  input  logic              clk,
  input  logic              rstN,
  input  ramStrobes_t       strobes,
  input  logic [DATA_W-1:0] operand,
  input  logic              baseWrEn,
  input  logic [DATA_W-1:0] baseWrData,
  input  logic              dataWrEn,
  input  logic [DATA_W-1:0] dataWrData,
  output logic [DATA_W-1:0] dataReg
);

  localparam int LANES  = DATA_W / BYTE_W;
  localparam int ADDR_W = $clog2(RAM_BYTES);
  localparam int LANE_W = $bits(strobes.lane);
  localparam logic [DATA_W-1:0] LIMIT = DATA_W'(RAM_BYTES);

  logic [BYTE_W-1:0] mem [RAM_BYTES];
  logic [DATA_W-1:0] baseReg;
  logic [DATA_W-1:0] effAddr;
  logic              inRange;
  logic [ADDR_W-1:0] memIdx;
  logic [BYTE_W-1:0] laneByte;
  logic [BYTE_W-1:0] rdQ;
  logic              rdPend;
  logic [LANE_W-1:0] pendLane;
  logic [DATA_W-1:0] mergeVal;
  logic [DATA_W-1:0] pendMask;

  // full-width adder, range check on the whole sum
  assign effAddr = operand + (strobes.useBase ? baseReg : '0);
  assign inRange = (effAddr < LIMIT);
  assign memIdx  = effAddr[ADDR_W-1:0];

  always_comb begin
    laneByte = '0;
    for (int i = 0; i < LANES; i++)
      if (strobes.lane == LANE_W'(i)) laneByte = dataReg[i*BYTE_W +: BYTE_W];
  end

  // RAM: write port and registered read port, no reset
  always_ff @(posedge clk) begin
    if (strobes.wrEn && inRange) mem[memIdx] <= laneByte;
    if (strobes.rdEn && inRange) rdQ <= mem[memIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPend   <= 1'b0;
      pendLane <= '0;
    end else begin
      rdPend   <= strobes.rdEn && inRange;
      pendLane <= strobes.lane;
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign mergeVal[g*BYTE_W +: BYTE_W] =
        (pendLane == LANE_W'(g)) ? rdQ : dataReg[g*BYTE_W +: BYTE_W];
      assign pendMask[g*BYTE_W +: BYTE_W] =
        (pendLane == LANE_W'(g)) ? '1 : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
      baseReg <= '0;
    end else begin
      if (rdPend)        dataReg <= mergeVal;
      else if (dataWrEn) dataReg <= dataWrData;
      if (baseWrEn)      baseReg <= baseWrData;
    end
  end

  // R3
  lane_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdPend |=> (((dataReg ^ $past(dataReg)) & ~$past(pendMask)) == '0));

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdPend && !dataWrEn) |=> $stable(dataReg));

  // R5
  base_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !baseWrEn |=> $stable(baseReg));

  // R6
  oob_nopend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdEn && (effAddr >= LIMIT)) |=> !rdPend);

endmodule

// File: rtl/lane_ram_unit.sv
module lane_ram_unit
  import lane_ram_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int BYTE_W    = 8,
  parameter int RAM_BYTES = 3072,
  parameter int OP_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] operand,
  input  logic              baseWrEn,
  input  logic [DATA_W-1:0] baseWrData,
  input  logic              dataWrEn,
  input  logic [DATA_W-1:0] dataWrData,
  output logic [DATA_W-1:0] dataReg,
  output logic              illegalOp
);

  ramStrobes_t strobes;

  lane_ram_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .opcode    (opcode),
    .strobes   (strobes),
    .illegalOp (illegalOp)
  );

  lane_ram_dpath #(
    .DATA_W    (DATA_W),
    .BYTE_W    (BYTE_W),
    .RAM_BYTES (RAM_BYTES)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .operand    (operand),
    .baseWrEn   (baseWrEn),
    .baseWrData (baseWrData),
    .dataWrEn   (dataWrEn),
    .dataWrData (dataWrData),
    .dataReg    (dataReg)
  );

endmodule

// File: tb/lane_ram_unit_tb.sv
`timescale 1ns/1ps
module lane_ram_unit_tb_top;

  localparam int NBYTES = 3072;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [15:0] opcode = '0;
  logic [23:0] operand = '0;
  logic        baseWrEn = 1'b0;
  logic [23:0] baseWrData = '0;
  logic        dataWrEn = 1'b0;
  logic [23:0] dataWrData = '0;
  logic [23:0] dataReg;
  logic        illegalOp;

  logic [7:0] model [NBYTES];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lane_ram_unit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode),
    .operand(operand), .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .dataWrEn(dataWrEn), .dataWrData(dataWrData),
    .dataReg(dataReg), .illegalOp(illegalOp)
  );

  function automatic logic [15:0] rdOp(input int lane, input bit based);
    return 16'h6800 | (16'(based) << 10) | (16'(lane) << 8);
  endfunction
  function automatic logic [15:0] wrOp(input int lane, input bit based);
    return 16'hE800 | (16'(based) << 10) | (16'(lane) << 8);
  endfunction
  function automatic logic [23:0] pat(input int a);
    return 24'(a * 24'h9E3779) ^ 24'h3C5A96;
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  task automatic loadData(input logic [23:0] v);
    @(negedge clk); dataWrEn = 1'b1; dataWrData = v;
    @(negedge clk); dataWrEn = 1'b0;
  endtask

  task automatic loadBase(input logic [23:0] v);
    @(negedge clk); baseWrEn = 1'b1; baseWrData = v;
    @(negedge clk); baseWrEn = 1'b0;
  endtask

  // presents one instruction; returns at the negedge after its first edge
  task automatic issue(input logic [15:0] op, input logic [23:0] opd);
    @(negedge clk); opValid = 1'b1; opcode = op; operand = opd;
    @(negedge clk); opValid = 1'b0; opcode = '0; operand = '0;
  endtask

  // load then sample after the merge edge
  task automatic doRead(input logic [15:0] op, input logic [23:0] opd);
    issue(op, opd);
    @(negedge clk);
  endtask

  function automatic logic [23:0] put(input logic [23:0] v, input int lane, input logic [7:0] b);
    logic [23:0] r = v;
    r[lane*8 +: 8] = b;
    return r;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%06h expected=%06h", 24'd0, 24'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] pre;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 dataReg", dataReg, 24'h0);
    chk("R1 illegalOp", 24'(illegalOp), 24'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", dataReg, 24'h0);

    // R11 direct load
    loadData(24'hABCDEF);
    chk("R11 direct load", dataReg, 24'hABCDEF);

    // R2 R4 fill every byte, lane rotating
    for (int a = 0; a < NBYTES; a++) begin
      loadData(pat(a));
      issue(wrOp(a % 3, 1'b0), 24'(a));
      model[a] = pat(a) >> ((a % 3) * 8);
    end

    // R3 R4 R5 read every byte, alternate direct and based forms
    loadBase(24'h000100);
    for (int a = 0; a < NBYTES; a++) begin
      int lane = (a / 3) % 3;
      bit based = (a >= 256) && a[0];
      pre = 24'hC3C3C3 ^ 24'(a * 24'h10101);
      loadData(pre);
      doRead(rdOp(lane, based), based ? 24'(a - 256) : 24'(a));
      chk("R3 R4 R5 lane merge", dataReg, put(pre, lane, model[a]));
    end

    // R6 out-of-range loads
    loadData(24'h112233);
    doRead(rdOp(0, 1'b1), 24'h000B00);
    chk("R6 based 0xC00 load", dataReg, 24'h112233);
    doRead(rdOp(1, 1'b0), 24'h000C00);
    chk("R6 direct 0xC00 load", dataReg, 24'h112233);
    doRead(rdOp(2, 1'b0), 24'hFFFFFF);
    chk("R6 top address load", dataReg, 24'h112233);
    doRead(rdOp(2, 1'b1), 24'h000AFF);
    chk("R6 edge 0xBFF load", dataReg, put(24'h112233, 2, model[12'hBFF]));

    // R7 out-of-range stores leave RAM alone
    loadData(24'h777777);
    issue(wrOp(0, 1'b0), 24'h001000);
    issue(wrOp(1, 1'b1), 24'h000B00);
    issue(wrOp(2, 1'b0), 24'h000C00);
    loadData(24'h000000);
    doRead(rdOp(0, 1'b0), 24'h000000);
    chk("R7 byte 0 untouched", dataReg, 24'(model[0]));
    loadData(24'h000000);
    doRead(rdOp(0, 1'b0), 24'h000BFF);
    chk("R7 byte 0xBFF untouched", dataReg, 24'(model[12'hBFF]));

    // R9 wrapped sum
    loadBase(24'hFFFFFF);
    loadData(24'h00E100);
    issue(wrOp(1, 1'b1), 24'h000006);
    model[5] = 8'hE1;
    loadData(24'h000000);
    doRead(rdOp(0, 1'b0), 24'h000005);
    chk("R9 wrap store to 5", dataReg, 24'h0000E1);
    loadData(24'h000000);
    doRead(rdOp(2, 1'b1), 24'h000007);
    chk("R9 wrap load from 6", dataReg, 24'(model[6]) << 16);

    // R8 lane code 3
    loadData(24'h5A5A5A);
    issue(rdOp(3, 1'b0), 24'h000010);
    chk("R8 pulse high", 24'(illegalOp), 24'h1);
    @(negedge clk);
    chk("R8 pulse ends", 24'(illegalOp), 24'h0);
    chk("R8 no load", dataReg, 24'h5A5A5A);
    issue(wrOp(3, 1'b0), 24'h000007);
    chk("R8 store pulse", 24'(illegalOp), 24'h1);
    loadData(24'h000000);
    doRead(rdOp(0, 1'b0), 24'h000007);
    chk("R8 no store", dataReg, 24'(model[7]));
    chk("R8 legal no pulse", 24'(illegalOp), 24'h0);

    // R10 no access
    loadData(24'h246802);
    doRead(16'h7000, 24'h000003);
    chk("R10 other major", dataReg, 24'h246802);
    @(negedge clk); opcode = rdOp(1, 1'b0); operand = 24'h3;
    @(negedge clk); opcode = '0;
    @(negedge clk);
    chk("R10 opValid low", dataReg, 24'h246802);

    // R1 second reset clears base and data
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    chk("R1 data cleared", dataReg, 24'h0);
    doRead(rdOp(0, 1'b1), 24'h000009);
    chk("R1 base cleared", dataReg, 24'(model[9]));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule